// File: doc/BRIEF.md
# Programmable CCD Horizontal Clock Generator

This block produces the horizontal transfer clocks for a CCD sensor, plus a last-stage clock, a reset-gate clock and two internal sampling strobes. Every pixel period is split into 64 phase slots by a free-running 6-bit phase counter. Each programmable channel drives its output high in the slot named by its rising-edge location and low in the slot named by its falling-edge location. A polarity bit optionally inverts the result.

A one-hot mode field fans one or two programmed waveforms onto eight horizontal outputs through fixed copy and inverse patterns. Each of the ten clock outputs also has a 3-bit drive setting, which is decoded into an output enable and a current-step count for the analog driver outside the block. Configuration arrives through a plain parallel write port. All writes land in a pending copy, and that copy moves to the active copy only when the phase counter wraps. A waveform therefore never changes in the middle of a pixel period. The write port has no back-pressure: a write is accepted on every clock where `wr_en` is high.

Top module: `hclk_gen`

## Requirements
- R1: The phase counter steps once per clock and wraps from 63 to 0. `pix_start` is high exactly when the counter is 0, so it is high on the first cycle after reset release and then once every 64 cycles.
- R2: A channel with polarity 1 and distinct locations has a level that becomes 1 one cycle after the counter equals its rising location and becomes 0 one cycle after the counter equals its falling location. Channel writes use these addresses: 0 for H1, 1 for H2, 2 for H5, 3 for last-stage and 4 for reset-gate. The data layout is rise [5:0], fall [11:6] and polarity [12].
- R3: Polarity 0 inverts the channel level on its output.
- R4: When a channel's rising and falling locations are equal, its level holds whatever value it had before.
- R5: Address 5 takes the reference-strobe slot in [5:0] and the data-strobe slot in [11:6]. Each strobe is a one-cycle pulse that appears one cycle after the counter equals its slot.
- R6: Address 6 sets the mode in bits [2:0]. In mode 001, `h_out[0]`, `h_out[2]`, `h_out[4]` and `h_out[6]` (H1, H3, H5, H7) equal H1, and the odd-numbered bits (H2, H4, H6, H8) equal its inverse.
- R7: In mode 010, the even-numbered bits of `h_out` equal H1, and the odd-numbered bits equal the independently programmed H2.
- R8: In mode 100, `h_out[0]` and `h_out[2]` equal H1, and `h_out[1]` and `h_out[3]` equal the inverse of H1. `h_out[4]` and `h_out[6]` equal H5, and `h_out[5]` and `h_out[7]` equal the inverse of H5.
- R9: The mode values 000, 011, 101, 110 and 111 force `h_out` to all zeros and raise `mode_err`.
- R10: Address 16+i sets the 3-bit drive of output i. Outputs 0 to 7 are H1 to H8, 8 is last-stage and 9 is reset-gate. A drive of 0 clears `drv_oe[i]` and gives 0 steps. A drive of 1 to 3 gives that many steps, and 4 to 7 give 4 steps. The step count appears at `drv_steps[3i+2:3i]`.
- R11: A write changes no output until the counter wraps. The new settings take effect from the cycle in which `pix_start` is high.
- R12: Reset leaves every location at 0, every polarity at 1, the mode at 001 and every drive at 0. The result is all `drv_oe` low, `h_out` = 8'hAA, the last-stage and reset-gate clocks low, and `mode_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one phase slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 5 | Configuration address |
| wr_data | input | 13 | Configuration data |
| h_out | output | 8 | Horizontal clocks H1 (bit 0) to H8 (bit 7) |
| lstage_out | output | 1 | Last-stage horizontal clock |
| rgate_out | output | 1 | Reset-gate clock |
| ref_strobe | output | 1 | Reference-level sampling pulse |
| data_strobe | output | 1 | Data-level sampling pulse |
| pix_start | output | 1 | High in the first slot of each pixel period |
| mode_err | output | 1 | Active mode value is not a legal one-hot code |
| drv_oe | output | 10 | Per-output driver enable |
| drv_steps | output | 30 | Per-output current-step count, 3 bits each |

## Verification
A corrupted phase counter shifts every edge and strobe together, and `pix_start` then leaves its 64-cycle spacing within one pixel period. A channel flop stuck at a wrong level, or one that ignores its hold rule, shows up at the routed `h_out` bits within the same period. A wrong copy from pending to active settings makes `mode_err` or `drv_oe` move on a cycle other than the period start, or makes the sweep after the next wrap disagree with the value that was written. The bench sweeps every slot of whole periods for several channel placements, including windows that cross the wrap. It also covers every mode code and every drive code.

// File: rtl/hclk_pkg.sv
package hclk_pkg;
  localparam int PH_W     = 6;
  localparam int NUM_PCH  = 5;
  localparam int NUM_OUT  = 10;
  localparam int DRV_W    = 3;
  localparam int CFG_W    = 2 * PH_W + 1;

  // programmable channel indices
  localparam int CH_H1 = 0;
  localparam int CH_H2 = 1;
  localparam int CH_H5 = 2;
  localparam int CH_LS = 3;
  localparam int CH_RG = 4;

  // write addresses
  localparam int ADR_STROBE = 5;
  localparam int ADR_MODE   = 6;
  localparam int ADR_DRV    = 16;

  localparam logic [2:0] MODE_MIRROR = 3'b001;
  localparam logic [2:0] MODE_PAIR   = 3'b010;
  localparam logic [2:0] MODE_QUAD   = 3'b100;

  typedef struct packed {
    logic            pol;
    logic [PH_W-1:0] fall;
    logic [PH_W-1:0] rise;
  } edge_cfg_t;

  typedef struct packed {
    edge_cfg_t [NUM_PCH-1:0]            ch;
    logic [PH_W-1:0]                    ref_slot;
    logic [PH_W-1:0]                    dat_slot;
    logic [2:0]                         mode;
    logic [NUM_OUT-1:0][DRV_W-1:0]      drv;
  } cfg_t;

  function automatic cfg_t cfg_reset();
    cfg_t c;
    c = '0;
    for (int i = 0; i < NUM_PCH; i++) c.ch[i].pol = 1'b1;
    c.mode = MODE_MIRROR;
    return c;
  endfunction
endpackage

// File: rtl/hclk_phase.sv
module hclk_phase #(
  parameter int PH_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase,
  output logic            wrap,
  output logic            start
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  assign wrap  = (phase == {PH_W{1'b1}});
  assign start = (phase == '0);
endmodule

// File: rtl/hclk_regs.sv
module hclk_regs
  import hclk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              wrap,
  output cfg_t              act
);
  cfg_t pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= cfg_reset();
    end else if (wr_en) begin
      for (int i = 0; i < NUM_PCH; i++)
        if (wr_addr == ADDR_W'(i)) pend.ch[i] <= wr_data;
      if (wr_addr == ADDR_W'(ADR_STROBE)) begin
        pend.ref_slot <= wr_data[PH_W-1:0];
        pend.dat_slot <= wr_data[2*PH_W-1:PH_W];
      end
      if (wr_addr == ADDR_W'(ADR_MODE)) pend.mode <= wr_data[2:0];
      for (int i = 0; i < NUM_OUT; i++)
        if (wr_addr == ADDR_W'(ADR_DRV + i)) pend.drv[i] <= wr_data[DRV_W-1:0];
    end
  end

  // active copy moves only at the period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act <= cfg_reset();
    else if (wrap) act <= pend;
  end
endmodule

// File: rtl/hclk_edge_ch.sv
module hclk_edge_ch
  import hclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] phase,
  input  edge_cfg_t       cfg,
  output logic            wave
);
  logic lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b0;
    end else if (cfg.rise != cfg.fall) begin
      if (phase == cfg.rise)      lvl <= 1'b1;
      else if (phase == cfg.fall) lvl <= 1'b0;
    end
  end

  assign wave = cfg.pol ? lvl : ~lvl;
endmodule

// File: rtl/hclk_route.sv
module hclk_route
  import hclk_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       src_h1,
  input  logic       src_h2,
  input  logic       src_h5,
  output logic [7:0] h,
  output logic       err
);
  always_comb begin
    h   = '0;
    err = 1'b0;
    for (int k = 0; k < 4; k++) begin
      case (mode)
        MODE_MIRROR: begin
          h[2*k]   = src_h1;
          h[2*k+1] = ~src_h1;
        end
        MODE_PAIR: begin
          h[2*k]   = src_h1;
          h[2*k+1] = src_h2;
        end
        MODE_QUAD: begin
          h[2*k]   = (k < 2) ? src_h1 : src_h5;
          h[2*k+1] = (k < 2) ? ~src_h1 : ~src_h5;
        end
        default: begin
          h[2*k]   = 1'b0;
          h[2*k+1] = 1'b0;
          err      = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/hclk_drive.sv
module hclk_drive #(
  parameter int NUM_OUT   = 10,
  parameter int DRV_W     = 3,
  parameter int STEP_W    = 3,
  parameter int MAX_STEPS = 4
) (
  input  logic [NUM_OUT-1:0][DRV_W-1:0] drv,
  output logic [NUM_OUT-1:0]            oe,
  output logic [NUM_OUT*STEP_W-1:0]     steps
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign oe[i] = |drv[i];
    assign steps[STEP_W*i +: STEP_W] =
      (drv[i] > DRV_W'(MAX_STEPS)) ? STEP_W'(MAX_STEPS) : STEP_W'(drv[i]);
  end
endmodule

// File: rtl/hclk_gen.sv
module hclk_gen
  import hclk_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int STEP_W    = 3,
  parameter int MAX_STEPS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [CFG_W-1:0]          wr_data,
  output logic [7:0]                h_out,
  output logic                      lstage_out,
  output logic                      rgate_out,
  output logic                      ref_strobe,
  output logic                      data_strobe,
  output logic                      pix_start,
  output logic                      mode_err,
  output logic [NUM_OUT-1:0]        drv_oe,
  output logic [NUM_OUT*STEP_W-1:0] drv_steps
);
  logic [PH_W-1:0]    phase;
  logic               wrap;
  cfg_t               act;
  logic [NUM_PCH-1:0] wave;

  hclk_phase #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase), .wrap(wrap), .start(pix_start)
  );

  hclk_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wrap(wrap), .act(act)
  );

  for (genvar i = 0; i < NUM_PCH; i++) begin : g_ch
    hclk_edge_ch u_ch (
      .clk(clk), .rst_n(rst_n), .phase(phase), .cfg(act.ch[i]), .wave(wave[i])
    );
  end

  hclk_route u_route (
    .mode(act.mode), .src_h1(wave[CH_H1]), .src_h2(wave[CH_H2]),
    .src_h5(wave[CH_H5]), .h(h_out), .err(mode_err)
  );

  assign lstage_out = wave[CH_LS];
  assign rgate_out  = wave[CH_RG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_strobe  <= 1'b0;
      data_strobe <= 1'b0;
    end else begin
      ref_strobe  <= (phase == act.ref_slot);
      data_strobe <= (phase == act.dat_slot);
    end
  end

  hclk_drive #(
    .NUM_OUT(NUM_OUT), .DRV_W(DRV_W), .STEP_W(STEP_W), .MAX_STEPS(MAX_STEPS)
  ) u_drive (
    .drv(act.drv), .oe(drv_oe), .steps(drv_steps)
  );
endmodule

// File: rtl/hclk_gen_chk.sv
module hclk_gen_chk #(
  parameter int NUM_OUT = 10,
  parameter int PH_W    = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pix_start,
  input logic [7:0]           h_out,
  input logic                 mode_err,
  input logic [NUM_OUT-1:0]   drv_oe,
  input logic [NUM_OUT*3-1:0] drv_steps
);
  logic [PH_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assert_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_start == (cnt == '0));

  assert_invalid_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (h_out == 8'h00));

  assert_mode_at_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_err) |-> pix_start);

  assert_oe_at_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv_oe) |-> pix_start);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_drv
    assert_steps_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      drv_steps[3*i +: 3] <= 3'd4);
    assert_off_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !drv_oe[i] |-> (drv_steps[3*i +: 3] == 3'd0));
  end
endmodule

bind hclk_gen hclk_gen_chk #(.NUM_OUT(hclk_pkg::NUM_OUT), .PH_W(hclk_pkg::PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_start(pix_start), .h_out(h_out),
  .mode_err(mode_err), .drv_oe(drv_oe), .drv_steps(drv_steps)
);

// File: tb/test_hclk_gen.sv
`timescale 1ns/1ps
module test_hclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [12:0] wr_data = '0;
  logic [7:0]  h_out;
  logic        lstage_out, rgate_out, ref_strobe, data_strobe, pix_start, mode_err;
  logic [9:0]  drv_oe;
  logic [29:0] drv_steps;

  int nchk = 0;
  int nfail = 0;
  int q = 0;
  bit done = 0;
  int br[5], bf[5], bp[5];
  int bref = 0, bdat = 0, bmode = 1;
  int bdrv[10];

  always #2.5 clk = ~clk;

  hclk_gen i_hclk_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .h_out(h_out), .lstage_out(lstage_out), .rgate_out(rgate_out),
    .ref_strobe(ref_strobe), .data_strobe(data_strobe), .pix_start(pix_start),
    .mode_err(mode_err), .drv_oe(drv_oe), .drv_steps(drv_steps)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h (slot %0d)", req, act, exp, q);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    q = (q + 1) % 64;
  endtask

  task automatic wr(int a, logic [12:0] d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic set_ch(int i, int r, int f, int p);
    br[i] = r; bf[i] = f; bp[i] = p;
    wr(i, {1'(p), 6'(f), 6'(r)});
  endtask

  // wait for the wrap that loads the pending copy, then one full period
  task automatic apply();
    do tick(); while (q != 0);
    repeat (64) tick();
  endtask

  function automatic bit lvl(int i, int s);
    int qm, dr, df;
    bit v;
    qm = (s + 63) % 64;
    dr = (qm - br[i] + 64) % 64;
    df = (qm - bf[i] + 64) % 64;
    v = (dr < df);
    return bp[i] != 0 ? v : !v;
  endfunction

  function automatic logic [7:0] exp_h(int m, bit a, bit b, bit c);
    logic [7:0] h;
    h = '0;
    for (int k = 0; k < 4; k++) begin
      if (m == 1)      begin h[2*k] = a; h[2*k+1] = !a; end
      else if (m == 2) begin h[2*k] = a; h[2*k+1] = b; end
      else if (m == 4) begin
        h[2*k] = (k < 2) ? a : c; h[2*k+1] = (k < 2) ? !a : !c;
      end
    end
    return h;
  endfunction

  task automatic sweep();
    string tag;
    tag = (bmode == 1) ? "R6" : (bmode == 2) ? "R7" : (bmode == 4) ? "R8" : "R9";
    for (int n = 0; n < 64; n++) begin
      chk(tag, 32'(h_out), 32'(exp_h(bmode, lvl(0, q), lvl(1, q), lvl(2, q))));
      chk("R9 mode_err", 32'(mode_err), 32'(!(bmode == 1 || bmode == 2 || bmode == 4)));
      chk("R2 last-stage", 32'(lstage_out), 32'(lvl(3, q)));
      chk("R3 reset-gate", 32'(rgate_out), 32'(lvl(4, q)));
      chk("R5 ref", 32'(ref_strobe), 32'(((q + 63) % 64) == bref));
      chk("R5 data", 32'(data_strobe), 32'(((q + 63) % 64) == bdat));
      chk("R1 pix_start", 32'(pix_start), 32'(q == 0));
      tick();
    end
  endtask

  task automatic check_drive();
    for (int i = 0; i < 10; i++) begin
      chk("R10 oe", 32'(drv_oe[i]), 32'(bdrv[i] != 0));
      chk("R10 steps", 32'(drv_steps[3*i +: 3]), 32'(bdrv[i] > 4 ? 4 : bdrv[i]));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 10; i++) bdrv[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    q = 0;

    // R12: reset state
    chk("R12 h_out", 32'(h_out), 32'h0AA);
    chk("R12 last-stage", 32'(lstage_out), 0);
    chk("R12 reset-gate", 32'(rgate_out), 0);
    chk("R12 mode_err", 32'(mode_err), 0);
    chk("R12 drv_oe", 32'(drv_oe), 0);
    chk("R12 drv_steps", 32'(drv_steps), 0);
    chk("R1 pix_start", 32'(pix_start), 1);

    // R2 R3 R5 R7: independent H1/H2, wrapping windows, inverted channels
    set_ch(0, 5, 20, 1);
    set_ch(1, 40, 10, 1);
    set_ch(2, 0, 63, 0);
    set_ch(3, 63, 1, 1);
    set_ch(4, 30, 31, 0);
    bref = 7; bdat = 50;
    wr(5, {1'b0, 6'(bdat), 6'(bref)});
    bmode = 2; wr(6, 13'd2);
    apply();
    sweep();

    // R6: mirror mode
    bmode = 1; wr(6, 13'd1);
    apply();
    sweep();

    // R8: quad mode with strobes at the period edges
    bref = 63; bdat = 0;
    wr(5, {1'b0, 6'(bdat), 6'(bref)});
    bmode = 4; wr(6, 13'd4);
    apply();
    sweep();

    // R9: every illegal mode code
    foreach (bdrv[k]) if (k < 5) begin
      int codes[5] = '{0, 3, 5, 6, 7};
      bmode = codes[k]; wr(6, 13'(codes[k]));
      apply();
      sweep();
    end

    // R4: equal locations hold the level, high then low
    bmode = 2; wr(6, 13'd2);
    set_ch(0, 50, 10, 1);
    apply();
    sweep();
    wr(0, {1'b1, 6'd20, 6'd20});
    apply();
    for (int n = 0; n < 64; n++) begin chk("R4 hold high", 32'(h_out[0]), 1); tick(); end
    set_ch(0, 5, 20, 1);
    apply();
    wr(0, {1'b1, 6'd30, 6'd30});
    apply();
    for (int n = 0; n < 64; n++) begin chk("R4 hold low", 32'(h_out[0]), 0); tick(); end
    set_ch(0, 5, 20, 1);

    // R10: all drive codes
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 10; i++) begin
        bdrv[i] = (i + 5 * k) % 8;
        wr(16 + i, 13'(bdrv[i]));
      end
      apply();
      check_drive();
    end

    // R11: writes wait for the wrap (output 0 drive is 5, mode legal)
    while (q != 2) tick();
    wr(6, 13'd3);
    wr(16, 13'd0);
    do begin
      chk("R11 mode held", 32'(mode_err), 0);
      chk("R11 oe held", 32'(drv_oe[0]), 1);
      tick();
    end while (q != 0);
    chk("R11 mode at wrap", 32'(mode_err), 1);
    chk("R11 oe at wrap", 32'(drv_oe[0]), 0);
    chk("R11 h at wrap", 32'(h_out), 0);

    finish_run();
  end
endmodule